// File: doc/BRIEF.md
# Cache Line Fill Engine

The engine turns a cache miss into bus reads on a Wishbone master port. For a line request it fetches four 32-bit words. The first word fetched is the one that missed, and the word position then wraps inside the 16-byte line. Each word is written into the line buffer together with its 2-bit position. For an uncached request it fetches one word and writes that word the same way. When the fetch ends, a one-cycle `done` pulse follows. A bus error ends the fetch early with a one-cycle `error` pulse and no `done`.

A mode input is sampled with each request and picks one of two timing schedules. The registered schedule spends two clocks on each word: a setup cycle with `cyc` high and `stb` low, then a strobe cycle. A single fetch also spends one more cycle with `cyc` low. The fast schedule suits a zero-wait on-chip SRAM. It holds `stb` high across the whole burst and steps the address on each acknowledge. The parameter `FAST_SETUP` can add a setup clock before the first word of a fast burst.

Top module: `line_fill_engine`

## Requirements
- R1: A line fill writes exactly four words. The write indices are s, s+1, s+2, s+3 modulo 4, where s is bits [3:2] of the request address. Each word is read from `{req_addr[31:4], index, 2'b00}`, and the data read is placed on `buf_data`.
- R2: In registered mode with a zero-wait slave, a line fill alternates a setup cycle (`cyc`=1, `stb`=0) with a strobe cycle. This gives eight bus clocks and four strobes, and `done` appears in the ninth cycle after the accepting edge.
- R3: In registered mode, a single fetch takes three clocks: a setup cycle, a strobe cycle, and an idle cycle with `cyc` low in which `done` pulses. One word is written, with index = address bits [3:2].
- R4: In fast mode with `FAST_SETUP`=0 and a zero-wait slave, `stb` stays high for four consecutive cycles. `done` follows in the fifth cycle after acceptance.
- R5: In fast mode, a single fetch takes two clocks: a strobe cycle, then an idle cycle with `cyc` low in which `done` pulses.
- R6: When `err` is asserted during a strobe, the fetch stops. The erroring word is not written, `done` is not pulsed, and `error` pulses for one cycle while `cyc` is low.
- R7: `req_ready` is high only while the engine is idle. A request presented while it is low is ignored: it produces no writes and no bus cycles.
- R8: `done` lasts one cycle, is never high together with `error`, and occurs only when `cyc` is low.
- R9: `stb` is high only while `cyc` is high. While `stb` waits for `ack`, `wb_adr_o` and `stb` hold steady, so each word takes one extra clock for every wait state.
- R10: After reset, `cyc`, `stb`, `done`, `error` and `buf_we` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fast_mode | input | 1 | Timing schedule, sampled with the request: 1 = fast, 0 = registered |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Byte address of the missed word |
| req_line | input | 1 | 1 = four-word line fill, 0 = single word |
| req_ready | output | 1 | Engine idle; a request is taken this cycle |
| done | output | 1 | One-cycle pulse when a fetch ends successfully |
| error | output | 1 | One-cycle pulse when a fetch is aborted by a bus error |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_adr_o | output | AW | Word-aligned bus address |
| wb_ack_i | input | 1 | Slave acknowledge |
| wb_err_i | input | 1 | Slave error |
| wb_dat_i | input | DW | Read data |
| buf_we | output | 1 | Line buffer write enable |
| buf_idx | output | 2 | Word position in the line |
| buf_data | output | DW | Word to store |

## Verification
Line fills start at different word positions, so the wrap of the index and the address is seen from more than one starting point. Each schedule is then paired with each request kind, and the cycle at which `done` appears, together with the number of strobe and cycle-active clocks, tells the four timings apart. A slave with one wait state shows that a stall stretches each word without moving the address. An error injected part way through a line, and a request presented while the engine is busy, show that the abort path and the ignore path leave the line buffer untouched.

// File: rtl/line_fill_engine.sv
module line_fill_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit FAST_SETUP = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast_mode,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_line,
  output logic          req_ready,
  output logic          done,
  output logic          error,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic [AW-1:0] wb_adr_o,
  input  logic          wb_ack_i,
  input  logic          wb_err_i,
  input  logic [DW-1:0] wb_dat_i,
  output logic          buf_we,
  output logic [1:0]    buf_idx,
  output logic [DW-1:0] buf_data
);
  typedef enum logic [1:0] {S_IDLE, S_GAP, S_STB, S_COOL} st_t;

  st_t           st;
  logic [AW-5:0] base;
  logic [1:0]    idx;
  logic [1:0]    cnt;
  logic          is_line;
  logic          is_fast;

  assign req_ready = (st == S_IDLE);
  assign wb_cyc_o  = (st == S_GAP) || (st == S_STB);
  assign wb_stb_o  = (st == S_STB);
  assign wb_adr_o  = {base, idx, 2'b00};
  assign buf_we    = wb_stb_o && wb_ack_i && !wb_err_i;
  assign buf_idx   = idx;
  assign buf_data  = wb_dat_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base    <= '0;
      idx     <= '0;
      cnt     <= '0;
      is_line <= 1'b0;
      is_fast <= 1'b0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          base    <= req_addr[AW-1:4];
          idx     <= req_addr[3:2];
          cnt     <= '0;
          is_line <= req_line;
          is_fast <= fast_mode;
          st      <= (!fast_mode || (req_line && FAST_SETUP)) ? S_GAP : S_STB;
        end
        S_GAP: st <= S_STB;
        S_STB: begin
          if (wb_err_i) begin
            error <= 1'b1;
            st    <= S_COOL;
          end else if (wb_ack_i) begin
            idx <= idx + 2'd1;
            cnt <= cnt + 2'd1;
            if (!is_line) begin
              done <= 1'b1;
              st   <= S_COOL;
            end else if (cnt == 2'd3) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= is_fast ? S_STB : S_GAP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_stb_in_cyc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb_o |-> wb_cyc_o);
  p_adr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && !wb_ack_i && !wb_err_i) |=> (wb_stb_o && $stable(wb_adr_o)));
  p_done_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!error && !wb_cyc_o));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && wb_err_i) |=> (error && !wb_cyc_o && !done));
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wb_cyc_o);
endmodule

// File: tb/line_fill_engine_tb.sv
module line_fill_engine_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] MAGIC = 32'h5A5A_0F0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_mode = 1'b0, req_valid = 1'b0, req_line = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, done, error, wb_cyc_o, wb_stb_o, buf_we;
  logic [AW-1:0] wb_adr_o;
  logic wb_ack_i, wb_err_i;
  logic [DW-1:0] wb_dat_i, buf_data;
  logic [1:0] buf_idx;

  logic slow = 1'b0, err_on = 1'b0, waited = 1'b0;
  logic [1:0] err_idx = '0;

  int total = 0, bad = 0;
  int nwr, nstb, ncyc;
  logic [1:0]  widx [8];
  logic [31:0] wadr [8];
  logic [31:0] wdat [8];

  always #2.5 clk = ~clk;

  line_fill_engine #(.AW(AW), .DW(DW), .FAST_SETUP(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .req_valid(req_valid),
    .req_addr(req_addr), .req_line(req_line), .req_ready(req_ready),
    .done(done), .error(error), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
    .wb_adr_o(wb_adr_o), .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i),
    .wb_dat_i(wb_dat_i), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data));

  assign wb_err_i = wb_stb_o && err_on && (wb_adr_o[3:2] == err_idx);
  assign wb_ack_i = wb_stb_o && !wb_err_i && (!slow || waited);
  assign wb_dat_i = wb_adr_o ^ MAGIC;

  always @(posedge clk) waited <= wb_stb_o && !wb_ack_i;

  always @(negedge clk) begin
    if (buf_we) begin
      if (nwr < 8) begin
        widx[nwr] = buf_idx;
        wadr[nwr] = wb_adr_o;
        wdat[nwr] = buf_data;
      end
      nwr++;
    end
    if (wb_stb_o) nstb++;
    if (wb_cyc_o) ncyc++;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] a, input logic line, input logic fast,
                        input int inject_k, output int lat, output logic gd, output logic ge);
    int k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nwr = 0; nstb = 0; ncyc = 0;
    req_addr = a; req_line = line; fast_mode = fast; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; gd = 1'b0; ge = 1'b0; lat = 0;
    while (k < 40) begin
      if (k == inject_k) begin req_valid = 1'b1; req_addr = 32'h0000_9990; req_line = 1'b0; end
      if (k == inject_k + 1) req_valid = 1'b0;
      if (done || error) begin gd = done; ge = error; lat = k; break; end
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    if (lat == 0) chk("watchdog", 0, 1);
  endtask

  task automatic chk_line(input string r, input logic [31:0] a);
    logic [1:0] s = a[3:2];
    chk(r, nwr, 4);
    for (int i = 0; i < 4; i++) begin
      logic [1:0] e = s + i[1:0];
      logic [31:0] ea = {a[31:4], e, 2'b00};
      chk(r, widx[i], e);
      chk(r, wadr[i], ea);
      chk(r, wdat[i], ea ^ MAGIC);
    end
  endtask

  task automatic t_reset;
    chk("R10 cyc", wb_cyc_o, 0); chk("R10 stb", wb_stb_o, 0);
    chk("R10 done", done, 0);    chk("R10 error", error, 0);
    chk("R10 we", buf_we, 0);    chk("R10 ready", req_ready, 1);
  endtask

  task automatic t_base_line(input logic [31:0] a);
    int lat; logic gd, ge;
    do_req(a, 1'b1, 1'b0, -5, lat, gd, ge);
    chk("R2 latency", lat, 9); chk("R2 stb", nstb, 4); chk("R2 cyc", ncyc, 8);
    chk("R8 done", gd, 1); chk("R8 cyc at done", wb_cyc_o, 0);
    chk_line("R1 wrap", a);
    @(negedge clk); chk("R8 pulse", done, 0);
  endtask

  task automatic t_base_single(input logic [31:0] a);
    int lat; logic gd, ge;
    do_req(a, 1'b0, 1'b0, -5, lat, gd, ge);
    chk("R3 latency", lat, 3); chk("R3 stb", nstb, 1); chk("R3 cyc", ncyc, 2);
    chk("R3 idle", wb_cyc_o, 0); chk("R3 writes", nwr, 1);
    chk("R3 idx", widx[0], a[3:2]); chk("R3 data", wdat[0], {a[31:2], 2'b00} ^ MAGIC);
    @(negedge clk); chk("R3 ready", req_ready, 1);
  endtask

  task automatic t_fast_line(input logic [31:0] a);
    int lat; logic gd, ge;
    do_req(a, 1'b1, 1'b1, -5, lat, gd, ge);
    chk("R4 latency", lat, 5); chk("R4 stb", nstb, 4); chk("R4 cyc", ncyc, 4);
    chk_line("R1 fast wrap", a);
  endtask

  task automatic t_fast_single(input logic [31:0] a);
    int lat; logic gd, ge;
    do_req(a, 1'b0, 1'b1, -5, lat, gd, ge);
    chk("R5 latency", lat, 2); chk("R5 stb", nstb, 1); chk("R5 idle", wb_cyc_o, 0);
    chk("R5 writes", nwr, 1); chk("R5 idx", widx[0], a[3:2]);
    @(negedge clk); chk("R5 ready", req_ready, 1);
  endtask

  task automatic t_err;
    int lat; logic gd, ge;
    err_on = 1'b1; err_idx = 2'd3;
    do_req(32'h0000_2004, 1'b1, 1'b0, -5, lat, gd, ge);
    chk("R6 error", ge, 1); chk("R6 no done", gd, 0); chk("R6 latency", lat, 7);
    chk("R6 cyc low", wb_cyc_o, 0); chk("R6 writes", nwr, 2);
    chk("R6 idx0", widx[0], 2'd1); chk("R6 idx1", widx[1], 2'd2);
    @(negedge clk); chk("R6 pulse", error, 0);
    err_on = 1'b0;
    t_fast_single(32'h0000_2008);
  endtask

  task automatic t_busy;
    int lat; logic gd, ge;
    do_req(32'h0000_3008, 1'b1, 1'b0, 3, lat, gd, ge);
    chk("R7 latency", lat, 9); chk_line("R7 line intact", 32'h0000_3008);
    repeat (4) @(negedge clk);
    chk("R7 no extra writes", nwr, 4); chk("R7 no extra cyc", ncyc, 8);
    chk("R7 ready", req_ready, 1);
  endtask

  task automatic t_slow;
    int lat; logic gd, ge;
    slow = 1'b1;
    do_req(32'h0000_400C, 1'b1, 1'b1, -5, lat, gd, ge);
    chk("R9 latency", lat, 9); chk("R9 stb", nstb, 8);
    chk_line("R9 addresses", 32'h0000_400C);
    slow = 1'b0;
  endtask

  initial begin
    fork
      begin
        #5000000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_line(32'h0000_1008);
    t_base_line(32'h0000_1100);
    t_base_single(32'h0000_1234);
    t_fast_line(32'h0000_500C);
    t_fast_line(32'h0000_5004);
    t_fast_single(32'h0000_6008);
    t_err();
    t_busy();
    t_slow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule